// File: doc/BRIEF.md
# Keyed Configuration Port

This block is the device side of a two-byte configuration port on a simple byte-wide I/O bus. The bus gives a small offset, read and write strobes and write data. The port stays locked until a fixed key byte is written to its index register twice in a row. While it is unlocked, software writes a register number to the index register. It then reads or writes that register through the data register.

The register file behind the port holds read-only chip and manufacturer identifiers, a logical-device select register, and a banked pair of base-address bytes for each logical device. The base address programmed for the hardware-monitor device leaves the block on a dedicated output, so external decode logic can place that device's 8-byte window. The decoder ignores the low three address bits, so they always read back as zero.

Top module: `cfgport_top`

## Requirements
- R1: Writing the open key 0x87 twice in a row to the index register (offset 5) unlocks the port. A single key write leaves it locked.
- R2: Any other byte written to the index register after one key write restarts the sequence, and two more key writes are then needed.
- R3: Writing 0xAA to the index register while unlocked relocks the port. The index is not changed.
- R4: While locked, reads at offset 5 or 6 return 0xFF. Data writes (offset 6) and index writes other than key bytes change no register.
- R5: While unlocked, an index write stores the register number. A read at offset 5 returns that number, and a read at offset 6 returns the selected register.
- R6: Register 0x20/0x21 returns the chip identifier (high/low byte) and 0x23/0x24 returns the manufacturer identifier 0x1934. Writes to these registers are ignored.
- R7: Register 0x07 is a read/write logical-device number. Registers 0x60 (high) and 0x61 (low) access the base address of the selected device, and each device keeps its own base address.
- R8: Bits 2..0 of the base low byte are not stored and read as 0. `hwm_base` always equals the base address of logical device 4.
- R9: After reset the port is locked, the index and device number are 0, every base address is 0, and `hwm_base` is 0.
- R10: Unimplemented register numbers read 0x00. Registers 0x60/0x61 read 0x00 and ignore writes when the device number is 8 or more.
- R11: `bus_rdata` is 0x00 when `bus_rd` is low. A read at any offset other than 5 or 6 returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_off | input | 3 | Byte offset inside the port window |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| hwm_base | output | 16 | Base address of the hardware-monitor device, low 3 bits zero |

## Verification
The unlock logic is driven with a clean pair of key writes, a single key, and a key–stray byte–key pattern. These show whether the block really needs two consecutive keys or just counts them. Register access is then tried with several device numbers, including one beyond the implemented range. This shows whether the banked base bytes are kept separately per device and whether only device 4 reaches the output. Writes made while locked and writes to the identifier registers are followed by reads that would expose any leaked update. A behavioural model compares read data and the base output on every clock.

// File: rtl/cfgport_pkg.sv
// Shared types and register numbers for the keyed configuration port.
// Assumes an 8-bit index space; numbers below are seen by software.
package cfgport_pkg;
    typedef enum logic [1:0] {
        LK_SHUT = 2'd0,
        LK_HALF = 2'd1,
        LK_OPEN = 2'd2
    } lock_state_t;

    localparam logic [7:0] REG_LDN     = 8'h07;
    localparam logic [7:0] REG_CHIP_HI = 8'h20;
    localparam logic [7:0] REG_CHIP_LO = 8'h21;
    localparam logic [7:0] REG_MFG_HI  = 8'h23;
    localparam logic [7:0] REG_MFG_LO  = 8'h24;
    localparam logic [7:0] REG_BASE_HI = 8'h60;
    localparam logic [7:0] REG_BASE_LO = 8'h61;
endpackage

// File: rtl/cfgport_lock.sv
// Lock state machine: opens after two consecutive open-key writes to the
// index register, closes on the close key. Assumes idx_wr is a one-cycle
// qualified write to the index offset.
module cfgport_lock
    import cfgport_pkg::*;
#(
    parameter logic [7:0] KEY_OPEN  = 8'h87,
    parameter logic [7:0] KEY_CLOSE = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       open_o
);
    lock_state_t state_q;

    // Advance the key sequence on every index write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_SHUT;
        end else if (idx_wr) begin
            case (state_q)
                LK_SHUT: state_q <= (wdata == KEY_OPEN) ? LK_HALF : LK_SHUT;
                LK_HALF: state_q <= (wdata == KEY_OPEN) ? LK_OPEN : LK_SHUT;
                LK_OPEN: state_q <= (wdata == KEY_CLOSE) ? LK_SHUT : LK_OPEN;
                default: state_q <= LK_SHUT;
            endcase
        end
    end

    assign open_o = (state_q == LK_OPEN);

    AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(idx_wr && wdata == KEY_OPEN)); // R1

    AST_STRAY_KEEPS_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_o && idx_wr && wdata != KEY_OPEN) |=> !open_o); // R2

    AST_CLOSE_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (open_o && idx_wr && wdata == KEY_CLOSE) |=> !open_o); // R3
endmodule

// File: rtl/cfgport_regs.sv
// Configuration register file: index, logical-device number, read-only
// identifiers and one banked base address per logical device. Assumes
// idx_load is already qualified by the lock state; data writes are
// qualified here with open_i.
module cfgport_regs
    import cfgport_pkg::*;
#(
    parameter int          NUM_LDEV = 8,
    parameter int          HWM_LDN  = 4,
    parameter int          ADDR_W   = 16,
    parameter int          WIN_BITS = 3,
    parameter logic [15:0] CHIP_ID  = 16'h0541,
    parameter logic [15:0] MFG_ID   = 16'h1934
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_i,
    input  logic              idx_load,
    input  logic              dat_wr,
    input  logic [7:0]        wdata,
    output logic [7:0]        idx_o,
    output logic [7:0]        dat_o,
    output logic [ADDR_W-1:0] hwm_base_o
);
    localparam int         LDN_W   = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1;
    localparam logic [7:0] LO_MASK = 8'(8'hFF << WIN_BITS);

    logic [7:0]        idx_q;
    logic [7:0]        ldn_q;
    logic [ADDR_W-1:0] base_q [NUM_LDEV];
    logic              wr_ok;
    logic              sel_ok;
    logic [ADDR_W-1:0] sel_base;

    assign wr_ok    = dat_wr && open_i;
    assign sel_ok   = (ldn_q < 8'(NUM_LDEV));
    assign sel_base = base_q[ldn_q[LDN_W-1:0]];

    // Hold the register number chosen by the last accepted index write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= 8'h00;
        else if (idx_load)
            idx_q <= wdata;
    end

    // Logical-device number, written through the data register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ldn_q <= 8'h00;
        else if (wr_ok && idx_q == REG_LDN)
            ldn_q <= wdata;
    end

    // One base-address register per logical device.
    for (genvar d = 0; d < NUM_LDEV; d++) begin : g_dev
        logic hit;
        assign hit = wr_ok && (ldn_q == 8'(d));

        // Update this device's base bytes when it is the selected one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[d] <= '0;
            end else if (hit && idx_q == REG_BASE_HI) begin
                base_q[d][ADDR_W-1:8] <= wdata[ADDR_W-9:0];
            end else if (hit && idx_q == REG_BASE_LO) begin
                base_q[d][7:0] <= wdata & LO_MASK;
            end
        end
    end

    // Read multiplexer for the data register.
    always_comb begin
        case (idx_q)
            REG_LDN:     dat_o = ldn_q;
            REG_CHIP_HI: dat_o = CHIP_ID[15:8];
            REG_CHIP_LO: dat_o = CHIP_ID[7:0];
            REG_MFG_HI:  dat_o = MFG_ID[15:8];
            REG_MFG_LO:  dat_o = MFG_ID[7:0];
            REG_BASE_HI: dat_o = sel_ok ? 8'(sel_base[ADDR_W-1:8]) : 8'h00;
            REG_BASE_LO: dat_o = sel_ok ? sel_base[7:0] : 8'h00;
            default:     dat_o = 8'h00;
        endcase
    end

    assign idx_o      = idx_q;
    assign hwm_base_o = base_q[HWM_LDN];

    AST_BASE_HELD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !open_i |=> $stable(hwm_base_o)); // R4

    AST_LDN_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ok && idx_q == REG_LDN) |=> $stable(ldn_q)); // R7

    AST_INDEX_HELD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !open_i |=> $stable(idx_q)); // R4
endmodule

// File: rtl/cfgport_top.sv
// Keyed two-byte configuration port. Decodes the index and data offsets,
// gates access with the lock machine, and exports the hardware-monitor
// base address. Assumes bus_rd and bus_wr are not raised together.
module cfgport_top
    import cfgport_pkg::*;
#(
    parameter int          OFF_W     = 3,
    parameter int          IDX_OFF   = 5,
    parameter int          DAT_OFF   = 6,
    parameter logic [7:0]  KEY_OPEN  = 8'h87,
    parameter logic [7:0]  KEY_CLOSE = 8'hAA,
    parameter int          NUM_LDEV  = 8,
    parameter int          HWM_LDN   = 4,
    parameter int          ADDR_W    = 16,
    parameter int          WIN_BITS  = 3,
    parameter logic [15:0] CHIP_ID   = 16'h0541,
    parameter logic [15:0] MFG_ID    = 16'h1934
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  bus_off,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [ADDR_W-1:0] hwm_base
);
    logic       at_idx, at_dat;
    logic       idx_wr, dat_wr, idx_load;
    logic       open;
    logic [7:0] idx_val, dat_val;

    assign at_idx   = (bus_off == OFF_W'(IDX_OFF));
    assign at_dat   = (bus_off == OFF_W'(DAT_OFF));
    assign idx_wr   = bus_wr && at_idx;
    assign dat_wr   = bus_wr && at_dat;
    assign idx_load = idx_wr && open && (bus_wdata != KEY_CLOSE);

    cfgport_lock #(
        .KEY_OPEN (KEY_OPEN),
        .KEY_CLOSE(KEY_CLOSE)
    ) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .idx_wr(idx_wr),
        .wdata (bus_wdata),
        .open_o(open)
    );

    cfgport_regs #(
        .NUM_LDEV(NUM_LDEV),
        .HWM_LDN (HWM_LDN),
        .ADDR_W  (ADDR_W),
        .WIN_BITS(WIN_BITS),
        .CHIP_ID (CHIP_ID),
        .MFG_ID  (MFG_ID)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_i    (open),
        .idx_load  (idx_load),
        .dat_wr    (dat_wr),
        .wdata     (bus_wdata),
        .idx_o     (idx_val),
        .dat_o     (dat_val),
        .hwm_base_o(hwm_base)
    );

    // Combinational read data: locked or undecoded reads give all ones.
    always_comb begin
        if (!bus_rd)
            bus_rdata = 8'h00;
        else if (at_idx)
            bus_rdata = open ? idx_val : 8'hFF;
        else if (at_dat)
            bus_rdata = open ? dat_val : 8'hFF;
        else
            bus_rdata = 8'hFF;
    end

    AST_LOCKED_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && bus_rd && (at_idx || at_dat)) |-> bus_rdata == 8'hFF); // R4

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == 8'h00); // R11
endmodule

// File: tb/cfgport_top_tb.sv
// Bench for cfgport_top: directed register traffic plus a behavioural
// model compared against the outputs on every clock.
module cfgport_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_off = 3'd0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [15:0] hwm_base;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit started = 0;
    bit done = 0;

    // Behavioural model state
    int       m_keys = 0;          // 0 none, 1 one key seen, 2 unlocked
    int       m_idx = 0;
    int       m_ldn = 0;
    int       m_hi[8];
    int       m_lo[8];

    cfgport_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_off  (bus_off),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .hwm_base (hwm_base)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int model_reg(input int idx);
        case (idx)
            'h07: return m_ldn;
            'h20: return 'h05;
            'h21: return 'h41;
            'h23: return 'h19;
            'h24: return 'h34;
            'h60: return (m_ldn < 8) ? m_hi[m_ldn] : 0;
            'h61: return (m_ldn < 8) ? m_lo[m_ldn] : 0;
            default: return 0;
        endcase
    endfunction

    function automatic int model_rdata();
        if (!bus_rd) return 0;
        if (bus_off == 3'd5) return (m_keys == 2) ? m_idx : 'hFF;
        if (bus_off == 3'd6) return (m_keys == 2) ? model_reg(m_idx) : 'hFF;
        return 'hFF;
    endfunction

    // Model update at each clock edge from the held inputs.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_keys = 0; m_idx = 0; m_ldn = 0;
            for (int i = 0; i < 8; i++) begin m_hi[i] = 0; m_lo[i] = 0; end
        end else if (bus_wr && bus_off == 3'd5) begin
            if (m_keys == 2) begin
                if (bus_wdata == 8'hAA) m_keys = 0;
                else m_idx = int'(bus_wdata);
            end else if (bus_wdata == 8'h87) begin
                m_keys = m_keys + 1;
            end else begin
                m_keys = 0;
            end
        end else if (bus_wr && bus_off == 3'd6 && m_keys == 2) begin
            if (m_idx == 'h07) m_ldn = int'(bus_wdata);
            else if (m_idx == 'h60 && m_ldn < 8) m_hi[m_ldn] = int'(bus_wdata);
            else if (m_idx == 'h61 && m_ldn < 8) m_lo[m_ldn] = int'(bus_wdata) & 'hF8;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        #2;
        if (started && !done) begin
            chk("MODEL rdata R5", int'(bus_rdata), model_rdata());
            chk("MODEL hwm_base R8", int'(hwm_base), (m_hi[4] << 8) | m_lo[4]);
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: got %0d cycles expected under %0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input int off, input int val);
        @(negedge clk);
        bus_off = 3'(off); bus_wr = 1'b1; bus_rd = 1'b0; bus_wdata = 8'(val);
    endtask

    task automatic rd(input int off, output int val);
        @(negedge clk);
        bus_off = 3'(off); bus_wr = 1'b0; bus_rd = 1'b1;
        #3 val = int'(bus_rdata);
    endtask

    task automatic idle();
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_off = 3'd0;
    endtask

    task automatic setreg(input int idx, input int val);
        wr(5, idx); wr(6, val);
    endtask

    task automatic getreg(input int idx, output int val);
        wr(5, idx); rd(6, val);
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        #3 chk("R9 hwm_base after reset", int'(hwm_base), 0);
        rd(6, v); chk("R9 locked after reset", v, 'hFF);
        idle(); #3 chk("R11 no read gives zero", int'(bus_rdata), 0);

        wr(5, 'h87); rd(6, v); chk("R1 single key stays locked", v, 'hFF);
        wr(5, 'h12); wr(5, 'h87); rd(5, v); chk("R2 stray byte restarts", v, 'hFF);
        wr(5, 'h87); rd(5, v); chk("R1 second key opens, index reset 0", v, 0);
        getreg('h07, v); chk("R9 device number reset 0", v, 0);

        getreg('h20, v); chk("R6 chip id high", v, 'h05);
        getreg('h21, v); chk("R6 chip id low", v, 'h41);
        getreg('h23, v); chk("R6 maker id high", v, 'h19);
        getreg('h24, v); chk("R6 maker id low", v, 'h34);
        wr(6, 'h55); rd(6, v); chk("R6 id ignores write", v, 'h34);
        getreg('h30, v); chk("R10 unimplemented reads zero", v, 0);
        rd(5, v); chk("R5 index readback", v, 'h30);

        setreg('h07, 4); getreg('h07, v); chk("R7 device number rw", v, 4);
        setreg('h60, 'h12); setreg('h61, 'h9F);
        getreg('h61, v); chk("R8 low bits cleared", v, 'h98);
        idle(); #3 chk("R8 hwm_base follows device 4", int'(hwm_base), 'h1298);
        setreg('h07, 2); setreg('h60, 'hAB); setreg('h61, 'hCD);
        getreg('h60, v); chk("R7 device 2 base high", v, 'hAB);
        idle(); #3 chk("R8 other device leaves hwm_base", int'(hwm_base), 'h1298);
        setreg('h07, 4); getreg('h60, v); chk("R7 device 4 kept its base", v, 'h12);
        setreg('h07, 9); setreg('h60, 'h77); getreg('h60, v);
        chk("R10 out-of-range device reads zero", v, 0);

        setreg('h07, 4); wr(5, 'h60);
        wr(5, 'hAA); rd(6, v); chk("R3 close key relocks", v, 'hFF);
        wr(6, 'h55); wr(5, 'h61);
        idle(); #3 chk("R4 locked write leaves hwm_base", int'(hwm_base), 'h1298);
        rd(3, v); chk("R11 other offset reads ones", v, 'hFF);
        wr(5, 'h87); wr(5, 'h87); rd(6, v);
        chk("R4 locked writes changed nothing, R3 index kept", v, 'h12);

        @(negedge clk); rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #3 chk("R9 reset clears base", int'(hwm_base), 0);
        rd(5, v); chk("R9 reset relocks", v, 'hFF);
        idle(); idle();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule